// File: doc/BRIEF.md
# Replicated-Register Steering Target Calculator

Registers that exist as several copies behind one address are read through a steering selector that names a group and an instance. A copy that is fused off or gated returns zero on reads and drops unicast writes, so each class of replicated register needs a target that points at a live copy. This block derives that target for every steering class from fuse and enable masks. Each target comes from a lowest-set-bit search, and the rule set selected by a mode input decides how the search result is split between the group and instance fields.

A caller drives the masks, the first enabled DSS index, a DSS-per-group count and the media engine presence bits, then pulses `start_i`. One cycle later `done_o` pulses, and the registered targets and per-class error flags stay put until the next start. The ceiling of subslices over slices is computed outside the block, and the result arrives on `dss_per_grp_i`. A zero on that input selects a per-mode fallback divisor. Choosing the mode is also left to the caller.

Class index order on the packed outputs: 0 L3 bank, 1 node, 2 memory slice, 3 cache fabric, 4 DSS, 5 media OA, 6 node interface, 7 fixed.

Top module: `steer_target_calc`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `err_o` and every group and instance field read 0.
- R2: `done_o` is high exactly in the cycle after a cycle with `start_i` high. Targets and error flags change only at an edge where `start_i` is high, and otherwise hold their values whatever the inputs do.
- R3: Mode 3 (newest): let b be the lowest set bit of `l3_mask_i` and n = b/4. The L3-bank target is group n, instance b mod 4. The node target is group n>>1, instance n&1. In every other mode the node target is 0/0 with its flag clear.
- R4: Mode 2 (intermediate): the L3-bank group is the lowest set bit m of `mslice_en_i`. The instance is 0 when bit 0 of `bank_excl_i` is set and 2 when it is clear.
- R5: Mode 1 (quad): the L3-bank group is (2·m) & 7 and the instance is 0, where m is the lowest set bit of `mslice_en_i`.
- R6: Mode 0 (legacy): the L3-bank instance is the lowest set bit of the bitwise inverse of `l3_mask_i`, and the group is 0.
- R7: The memory-slice target is group m, instance 0. The cache-fabric target is group 2·m, instance 0.
- R8: The DSS target is group `dss_idx_i` / d and instance `dss_idx_i` mod d, where d is `dss_per_grp_i`.
- R9: When `dss_per_grp_i` is 0, d is the fallback for the mode: 6 for mode 0, 4 for modes 1 and 2, and 8 for mode 3.
- R10: The node-interface target is group k>>1 and instance k&1, where k is the lowest set bit of `node_en_i`.
- R11: The media OA target is group 0 when either bit of `media_eng_i` is set and group 1 when both are clear. The instance is 0.
- R12: The fixed class always yields group 1, instance 0.
- R13: When a search needed by a class finds no set bit, that class's `err_o` bit is set and its target is 0/0. This covers the L3 bank (mode 3: `l3_mask_i` zero; mode 0: `l3_mask_i` all ones; modes 1 and 2: `mslice_en_i` zero), the node (mode 3, `l3_mask_i` zero), the memory slice and cache fabric (`mslice_en_i` zero) and the node interface (`node_en_i` zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture a new set of targets |
| mode_i | input | 2 | Rule set: 0 legacy, 1 quad, 2 intermediate, 3 newest |
| l3_mask_i | input | L3_W | L3 bank enable mask (raw fuse field in mode 0) |
| mslice_en_i | input | MSL_W | Memory-slice enable mask |
| bank_excl_i | input | EXCL_W | Bank-exclusion mask; only bit 0 is decoded |
| node_en_i | input | NODE_W | Node-interface enable mask |
| dss_idx_i | input | DSS_W | First enabled DSS index |
| dss_per_grp_i | input | DPG_W | DSS per group; 0 selects the fallback |
| media_eng_i | input | 2 | Presence of the first two video engines |
| done_o | output | 1 | One-cycle pulse after a start |
| err_o | output | 8 | Per-class empty-mask flag |
| grp_o | output | 8 x FLD_W | Per-class group target |
| inst_o | output | 8 x FLD_W | Per-class instance target |

## Verification
The bench uses the default parameters: a 16-bit L3 mask, a 4-bit memory-slice mask, an 8-bit node mask, 6-bit DSS indices, a 4-bit divisor and 8-bit fields. At these widths the top quad result (slice 3 wraps to group 6), the highest legacy bank (15) and the largest DSS index (63) can all be tested under every fallback divisor. The narrow masks also make the all-zero and all-ones cases easy to drive for each rule set, and the hold check runs against a fully changed input set.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NT = 8;
  localparam int T_L3     = 0;
  localparam int T_NODE   = 1;
  localparam int T_MSLICE = 2;
  localparam int T_FABRIC = 3;
  localparam int T_DSS    = 4;
  localparam int T_OA     = 5;
  localparam int T_NODEIF = 6;
  localparam int T_FIXED  = 7;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_QUAD   = 2'd1,
    MODE_MID    = 2'd2,
    MODE_NEW    = 2'd3
  } mode_e;
endpackage

// File: rtl/lsb_find.sv
module lsb_find #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = |vec_i;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/l3_rules.sv
module l3_rules
  import steer_pkg::*;
#(
  parameter int L3_W   = 16,
  parameter int MSL_IW = 2,
  parameter int FLD_W  = 8
) (
  input  mode_e              mode_i,
  input  logic [L3_W-1:0]    l3_mask_i,
  input  logic [MSL_IW-1:0]  ms_idx_i,
  input  logic               ms_found_i,
  input  logic               excl0_i,
  output logic [FLD_W-1:0]   l3_grp_o,
  output logic [FLD_W-1:0]   l3_inst_o,
  output logic               l3_err_o,
  output logic [FLD_W-1:0]   node_grp_o,
  output logic [FLD_W-1:0]   node_inst_o,
  output logic               node_err_o
);
  localparam int L3_IW = (L3_W > 1) ? $clog2(L3_W) : 1;

  logic [L3_IW-1:0] en_idx, fz_idx, node_n;
  logic             en_found, fz_found;
  logic [MSL_IW:0]  ms_x2;

  // enabled-bank search for the newest rule, inverted fuse for legacy
  lsb_find #(.W(L3_W)) u_en (.vec_i(l3_mask_i),  .idx_o(en_idx), .found_o(en_found));
  lsb_find #(.W(L3_W)) u_fz (.vec_i(~l3_mask_i), .idx_o(fz_idx), .found_o(fz_found));

  assign node_n = en_idx >> 2;
  assign ms_x2  = {ms_idx_i, 1'b0};

  always_comb begin
    l3_grp_o    = '0;
    l3_inst_o   = '0;
    l3_err_o    = 1'b0;
    node_grp_o  = '0;
    node_inst_o = '0;
    node_err_o  = 1'b0;
    unique case (mode_i)
      MODE_NEW: begin
        if (en_found) begin
          l3_grp_o    = FLD_W'(node_n);
          l3_inst_o   = FLD_W'(en_idx[1:0]);
          node_grp_o  = FLD_W'(node_n >> 1);
          node_inst_o = FLD_W'(node_n[0]);
        end else begin
          l3_err_o   = 1'b1;
          node_err_o = 1'b1;
        end
      end
      MODE_MID: begin
        if (ms_found_i) begin
          l3_grp_o  = FLD_W'(ms_idx_i);
          l3_inst_o = excl0_i ? FLD_W'(0) : FLD_W'(2);
        end else begin
          l3_err_o = 1'b1;
        end
      end
      MODE_QUAD: begin
        if (ms_found_i) l3_grp_o = FLD_W'(ms_x2) & FLD_W'(7);
        else            l3_err_o = 1'b1;
      end
      default: begin
        if (fz_found) l3_inst_o = FLD_W'(fz_idx);
        else          l3_err_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dss_split.sv
module dss_split
  import steer_pkg::*;
#(
  parameter int DSS_W = 6,
  parameter int DPG_W = 4,
  parameter int FLD_W = 8
) (
  input  mode_e             mode_i,
  input  logic [DSS_W-1:0]  idx_i,
  input  logic [DPG_W-1:0]  dpg_i,
  output logic [FLD_W-1:0]  grp_o,
  output logic [FLD_W-1:0]  inst_o
);
  logic [DSS_W-1:0] div, quo, rem;

  always_comb begin
    if (dpg_i != '0) begin
      div = DSS_W'(dpg_i);
    end else begin
      unique case (mode_i)
        MODE_NEW:               div = DSS_W'(8);
        MODE_MID, MODE_QUAD:    div = DSS_W'(4);
        default:                div = DSS_W'(6);
      endcase
    end
    quo = idx_i / div;
    rem = idx_i % div;
  end

  assign grp_o  = FLD_W'(quo);
  assign inst_o = FLD_W'(rem);
endmodule

// File: rtl/steer_target_calc.sv
module steer_target_calc
  import steer_pkg::*;
#(
  parameter int L3_W   = 16,
  parameter int MSL_W  = 4,
  parameter int EXCL_W = 3,
  parameter int NODE_W = 8,
  parameter int DSS_W  = 6,
  parameter int DPG_W  = 4,
  parameter int FLD_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [1:0]                 mode_i,
  input  logic [L3_W-1:0]            l3_mask_i,
  input  logic [MSL_W-1:0]           mslice_en_i,
  input  logic [EXCL_W-1:0]          bank_excl_i,
  input  logic [NODE_W-1:0]          node_en_i,
  input  logic [DSS_W-1:0]           dss_idx_i,
  input  logic [DPG_W-1:0]           dss_per_grp_i,
  input  logic [1:0]                 media_eng_i,
  output logic                       done_o,
  output logic [7:0]                 err_o,
  output logic [7:0][FLD_W-1:0]      grp_o,
  output logic [7:0][FLD_W-1:0]      inst_o
);
  localparam int MSL_IW  = (MSL_W > 1)  ? $clog2(MSL_W)  : 1;
  localparam int NODE_IW = (NODE_W > 1) ? $clog2(NODE_W) : 1;

  mode_e mode, mode_q;
  assign mode = mode_e'(mode_i);

  logic [MSL_IW-1:0]  ms_idx;
  logic               ms_found;
  logic [NODE_IW-1:0] nd_idx;
  logic               nd_found;
  logic [MSL_IW:0]    ms_x2;
  logic               unused_excl;

  assign unused_excl = ^bank_excl_i;

  lsb_find #(.W(MSL_W))  u_ms (.vec_i(mslice_en_i), .idx_o(ms_idx), .found_o(ms_found));
  lsb_find #(.W(NODE_W)) u_nd (.vec_i(node_en_i),   .idx_o(nd_idx), .found_o(nd_found));

  logic [NT-1:0][FLD_W-1:0] g_d, i_d;
  logic [NT-1:0]            e_d;

  l3_rules #(.L3_W(L3_W), .MSL_IW(MSL_IW), .FLD_W(FLD_W)) u_l3 (
    .mode_i      (mode),
    .l3_mask_i   (l3_mask_i),
    .ms_idx_i    (ms_idx),
    .ms_found_i  (ms_found),
    .excl0_i     (bank_excl_i[0]),
    .l3_grp_o    (g_d[T_L3]),
    .l3_inst_o   (i_d[T_L3]),
    .l3_err_o    (e_d[T_L3]),
    .node_grp_o  (g_d[T_NODE]),
    .node_inst_o (i_d[T_NODE]),
    .node_err_o  (e_d[T_NODE])
  );

  dss_split #(.DSS_W(DSS_W), .DPG_W(DPG_W), .FLD_W(FLD_W)) u_dss (
    .mode_i (mode),
    .idx_i  (dss_idx_i),
    .dpg_i  (dss_per_grp_i),
    .grp_o  (g_d[T_DSS]),
    .inst_o (i_d[T_DSS])
  );
  assign e_d[T_DSS] = 1'b0;

  assign ms_x2 = {ms_idx, 1'b0};

  always_comb begin
    g_d[T_MSLICE] = ms_found ? FLD_W'(ms_idx) : '0;
    i_d[T_MSLICE] = '0;
    e_d[T_MSLICE] = ~ms_found;
    g_d[T_FABRIC] = ms_found ? FLD_W'(ms_x2) : '0;
    i_d[T_FABRIC] = '0;
    e_d[T_FABRIC] = ~ms_found;
    g_d[T_OA]     = (|media_eng_i) ? FLD_W'(0) : FLD_W'(1);
    i_d[T_OA]     = '0;
    e_d[T_OA]     = 1'b0;
    g_d[T_NODEIF] = nd_found ? FLD_W'(nd_idx >> 1) : '0;
    i_d[T_NODEIF] = nd_found ? FLD_W'(nd_idx[0]) : '0;
    e_d[T_NODEIF] = ~nd_found;
    g_d[T_FIXED]  = FLD_W'(1);
    i_d[T_FIXED]  = '0;
    e_d[T_FIXED]  = 1'b0;
  end

  // per-class result registers, loaded only on start
  for (genvar t = 0; t < NT; t++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        grp_o[t]  <= '0;
        inst_o[t] <= '0;
        err_o[t]  <= 1'b0;
      end else if (start_i) begin
        grp_o[t]  <= g_d[t];
        inst_o[t] <= i_d[t];
        err_o[t]  <= e_d[t];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      mode_q <= MODE_LEGACY;
    end else begin
      done_o <= start_i;
      if (start_i) mode_q <= mode;
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);  // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);  // R2
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(grp_o) && $stable(inst_o) && $stable(err_o)));  // R2
  AST_FABRIC_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o[T_MSLICE]) |-> (grp_o[T_FABRIC] == (grp_o[T_MSLICE] << 1)));  // R7
  AST_NODE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_NEW && !err_o[T_L3]) |->
      (grp_o[T_L3] == FLD_W'({grp_o[T_NODE], inst_o[T_NODE][0]})));  // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[T_NODEIF] |-> (grp_o[T_NODEIF] == '0 && inst_o[T_NODEIF] == '0));  // R13
endmodule

// File: tb/steer_target_calc_tb_top.sv
module steer_target_calc_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [1:0]  mode;
  logic [15:0] l3;
  logic [3:0]  ms;
  logic [2:0]  excl;
  logic [7:0]  node;
  logic [5:0]  dss;
  logic [3:0]  dpg;
  logic [1:0]  eng;
  logic        done;
  logic [7:0]  err;
  logic [7:0][7:0] grp, inst;

  steer_target_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .l3_mask_i(l3), .mslice_en_i(ms), .bank_excl_i(excl), .node_en_i(node),
    .dss_idx_i(dss), .dss_per_grp_i(dpg), .media_eng_i(eng),
    .done_o(done), .err_o(err), .grp_o(grp), .inst_o(inst)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] l3;
    logic [3:0]  ms;
    logic [2:0]  excl;
    logic [7:0]  node;
    logic [5:0]  dss;
    logic [3:0]  dpg;
    logic [1:0]  eng;
    logic [7:0]  l3g, l3i, dg, di;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 16'h0060, 4'h4, 3'd0, 8'h0C, 6'd13, 4'd4, 2'd1, 8'd1, 8'd1,  8'd3,  8'd1},
    '{2'd3, 16'h1000, 4'h1, 3'd0, 8'h80, 6'd20, 4'd6, 2'd0, 8'd3, 8'd0,  8'd3,  8'd2},
    '{2'd2, 16'hFFFF, 4'hA, 3'd1, 8'h01, 6'd7,  4'd0, 2'd2, 8'd1, 8'd0,  8'd1,  8'd3},
    '{2'd2, 16'h0000, 4'h8, 3'd2, 8'h10, 6'd9,  4'd5, 2'd3, 8'd3, 8'd2,  8'd1,  8'd4},
    '{2'd1, 16'h0000, 4'h2, 3'd0, 8'h02, 6'd11, 4'd0, 2'd1, 8'd2, 8'd0,  8'd2,  8'd3},
    '{2'd1, 16'h0000, 4'h8, 3'd0, 8'h40, 6'd5,  4'd3, 2'd0, 8'd6, 8'd0,  8'd1,  8'd2},
    '{2'd0, 16'hFFF3, 4'h1, 3'd0, 8'h03, 6'd17, 4'd0, 2'd2, 8'd0, 8'd2,  8'd2,  8'd5},
    '{2'd0, 16'h7FFF, 4'h3, 3'd0, 8'h20, 6'd63, 4'd0, 2'd1, 8'd0, 8'd15, 8'd10, 8'd3},
    '{2'd3, 16'h0001, 4'hF, 3'd0, 8'hFF, 6'd63, 4'd0, 2'd3, 8'd0, 8'd0,  8'd7,  8'd7}
  };

  int n_chk = 0, n_fail = 0;
  int eg[8], ei[8];
  logic [7:0] ee;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lsb(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic string l3_req(input logic [1:0] m);
    case (m)
      2'd3: return "R3";
      2'd2: return "R4";
      2'd1: return "R5";
      default: return "R6";
    endcase
  endfunction

  // bench model for node, slice, fabric, OA, node-interface, fixed and flags
  task automatic model();
    int b, n, k, m;
    for (int t = 0; t < 8; t++) begin eg[t] = 0; ei[t] = 0; end
    ee = '0;
    b = lsb(l3);
    m = lsb({12'h0, ms});
    k = lsb({8'h0, node});
    if (mode == 2'd3) begin
      if (b < 0) begin ee[0] = 1'b1; ee[1] = 1'b1; end
      else begin n = b / 4; eg[1] = n / 2; ei[1] = n % 2; end
    end else if (mode == 2'd0) begin
      if (l3 == 16'hFFFF) ee[0] = 1'b1;
    end else if (m < 0) ee[0] = 1'b1;
    if (m < 0) begin ee[2] = 1'b1; ee[3] = 1'b1; end
    else begin eg[2] = m; eg[3] = 2 * m; end
    eg[5] = (eng != 2'd0) ? 0 : 1;
    if (k < 0) ee[6] = 1'b1;
    else begin eg[6] = k / 2; ei[6] = k % 2; end
    eg[7] = 1;
  endtask

  task automatic fire();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic chk_model();
    model();
    chk("R3",  "node grp",   grp[1],  eg[1]);
    chk("R3",  "node inst",  inst[1], ei[1]);
    chk("R7",  "slice grp",  grp[2],  eg[2]);
    chk("R7",  "slice inst", inst[2], 0);
    chk("R7",  "fabric grp", grp[3],  eg[3]);
    chk("R11", "oa grp",     grp[5],  eg[5]);
    chk("R11", "oa inst",    inst[5], 0);
    chk("R10", "nodeif grp", grp[6],  eg[6]);
    chk("R10", "nodeif inst",inst[6], ei[6]);
    chk("R12", "fixed grp",  grp[7],  1);
    chk("R12", "fixed inst", inst[7], 0);
    chk("R13", "err flags",  err,     ee);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; l3 = '0; ms = '0; excl = '0;
    node = '0; dss = '0; dpg = '0; eng = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset err",  err,  0);
    chk("R1", "reset grp",  (grp == '0) ? 1 : 0, 1);
    chk("R1", "reset inst", (inst == '0) ? 1 : 0, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      mode = VEC[v].mode; l3 = VEC[v].l3; ms = VEC[v].ms; excl = VEC[v].excl;
      node = VEC[v].node; dss = VEC[v].dss; dpg = VEC[v].dpg; eng = VEC[v].eng;
      fire();
      chk("R2", "done pulse", done, 1);
      chk(l3_req(VEC[v].mode), "l3 grp",  grp[0],  VEC[v].l3g);
      chk(l3_req(VEC[v].mode), "l3 inst", inst[0], VEC[v].l3i);
      chk((VEC[v].dpg == 0) ? "R9" : "R8", "dss grp",  grp[4],  VEC[v].dg);
      chk((VEC[v].dpg == 0) ? "R9" : "R8", "dss inst", inst[4], VEC[v].di);
      chk_model();
      @(negedge clk);
      chk("R2", "done falls", done, 0);
    end

    // hold: last vector's results must survive a full input change
    mode = 2'd1; l3 = 16'h0; ms = 4'h0; node = 8'h0; dss = 6'd1; dpg = 4'd1; eng = 2'd0;
    repeat (3) @(negedge clk);
    chk("R2", "hold done",     done,    0);
    chk("R2", "hold l3 grp",   grp[0],  0);
    chk("R2", "hold dss grp",  grp[4],  7);
    chk("R2", "hold dss inst", inst[4], 7);
    chk("R2", "hold err",      err,     0);

    // newest rule, every mask empty
    mode = 2'd3; l3 = 16'h0; ms = 4'h0; node = 8'h0; dss = 6'd0; dpg = 4'd0; eng = 2'd1;
    fire();
    chk("R13", "empty new l3 grp",  grp[0],  0);
    chk("R13", "empty new l3 inst", inst[0], 0);
    chk("R13", "empty new flags",   err,     8'h4F);
    chk_model();

    // legacy rule with every bank fused
    mode = 2'd0; l3 = 16'hFFFF; ms = 4'h1; node = 8'h01;
    fire();
    chk("R13", "legacy full l3 inst", inst[0], 0);
    chk("R13", "legacy full flags",   err,     8'h01);
    chk_model();

    // intermediate rule with no memory slice
    mode = 2'd2; ms = 4'h0; excl = 3'd1;
    fire();
    chk("R13", "mid empty l3 grp",  grp[0],  0);
    chk("R13", "mid empty l3 inst", inst[0], 0);
    chk("R13", "mid empty flags",   err,     8'h0D);
    chk_model();

    // intermediate rule: excl bits above bit 0 do not matter
    ms = 4'h4; excl = 3'd6;
    fire();
    chk("R4", "excl high bits inst", inst[0], 2);
    chk("R4", "excl high bits grp",  grp[0],  2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule